// File: doc/BRIEF.md
# Descriptor ring transmit DMA channel

This block is one transmit DMA channel. It walks a ring of descriptors held in system memory and turns each owned buffer into a byte stream for a MAC. Each descriptor is two 32-bit words. The first is a length and status word at ring offset 8·i. The second, at 8·i+4, is the buffer address. The ring has no length register: a wrap flag in a descriptor sends the engine back to the ring start address.

Software first programs the ring start address and the maximum burst length, then sets the enable bit. The engine fetches the descriptor at its current position. If the owner flag is set, it reads the buffer in word bursts and emits the bytes one per cycle with frame markers. It then writes the first word back with the owner flag cleared, posts completion status and moves on.

A descriptor that is not owned stops the engine until software writes the enable bit again. Software stops the channel with a handshake: it clears the enable bit and polls until the bit reads back low. The bit drops only once the engine is idle.

Top module: `txring_dma`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, the mask register reads 0, the maximum burst register reads 8, `irq` is low and no byte is streamed.
- R2: A descriptor's first word holds the byte length in bits 27:16, the owner flag in bit 15, end-of-packet in bit 14, start-of-packet in bit 13, wrap in bit 12 and append-CRC in bit 8. Its second word holds a word-aligned buffer address. The engine never reads and writes memory in the same cycle.
- R3: For an owned descriptor, all length bytes are streamed in address order, least significant byte of each word first, one per cycle with `st_valid` high. The first word is then written back, in the cycle after the last byte, with bit 15 cleared and every other bit unchanged.
- R4: After a descriptor with the wrap flag, the next fetch is at the ring start address. Otherwise the next fetch is 8 bytes further on.
- R5: Writing 0 to bit 0 of the control register (offset 0x00) while a descriptor is in flight leaves the bit reading 1 until that descriptor is written back. The bit then reads 0, and no further descriptor is fetched.
- R6: The status register (offset 0x04) has bit 0 for buffer done (any descriptor completed), bit 1 for packet done (a completed descriptor carried end-of-packet) and bit 2 for not-owner. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R7: `irq` is high exactly when some status bit is set and the same bit of the mask register (offset 0x08) is set.
- R8: Fetching a descriptor whose owner flag is 0 sets not-owner and idles the engine. The engine fetches nothing more until software writes 1 to the enable bit, and then it re-reads that same descriptor.
- R9: Buffer reads are grouped into bursts of at most the value in the maximum burst register (offset 0x0C, in 32-bit words, where 0 acts as 1). `mem_bstart` flags the first read of each burst. Each descriptor fetch is its own burst.
- R10: `st_sop` marks the first byte of a buffer whose descriptor has start-of-packet. `st_eop` marks the last byte of a buffer whose descriptor has end-of-packet. `st_crc` repeats the append-CRC flag on every byte.
- R11: A descriptor with length 0 streams no byte and reads no buffer word, but it is still written back and posts its status.
- R12: Writing the ring start register (offset 0x10) also moves the current position to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Masked status interrupt |
| mem_rd | output | 1 | Memory word read request; data returns the next cycle |
| mem_wr | output | 1 | Memory word write request |
| mem_bstart | output | 1 | First read of a burst |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| st_valid | output | 1 | Stream byte valid |
| st_data | output | 8 | Stream byte |
| st_sop | output | 1 | First byte of a frame |
| st_eop | output | 1 | Last byte of a frame |
| st_crc | output | 1 | MAC should append the CRC |

## Verification
A register write takes effect at the next clock edge, and register reads and `irq` follow the stored state in the same cycle, so the bench reads one cycle after each write. Memory read data is due one cycle after the request. The write-back is due in the cycle after the last byte. The enable bit falls one edge after the engine is idle. The bench waits for the write-back event and then lets a few cycles pass before it checks status, fetch order or the enable bit. Stream bytes, burst starts and fetch addresses are gathered on the falling edge, and stimulus changes one time unit after the rising edge.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;
  // length/status word fields
  localparam int LS_LEN_LSB = 16;
  localparam int LS_LEN_W   = 12;
  localparam int LS_OWN     = 15;
  localparam int LS_EOP     = 14;
  localparam int LS_SOP     = 13;
  localparam int LS_WRAP    = 12;
  localparam int LS_CRC     = 8;

  // register byte offsets
  localparam logic [4:0] RA_CFG  = 5'h00;
  localparam logic [4:0] RA_STS  = 5'h04;
  localparam logic [4:0] RA_MSK  = 5'h08;
  localparam logic [4:0] RA_MBR  = 5'h0C;
  localparam logic [4:0] RA_RING = 5'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LS, ST_RD_AD, ST_CAP, ST_BUF_RD, ST_BUF_OUT, ST_EMIT, ST_WB
  } eng_state_e;

  typedef struct packed {
    logic not_own;
    logic pkt_done;
    logic buf_done;
  } eng_evt_t;
endpackage

// File: rtl/txr_regs.sv
`timescale 1ns/1ps
module txr_regs
  import txr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MBW    = 8,
  parameter int MB_RST = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [4:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  eng_evt_t       evt,
  input  logic           eng_idle,
  input  logic           kick_ack,
  output logic           en,
  output logic           stop_pend,
  output logic           kick,
  output logic [MBW-1:0] max_burst,
  output logic [AW-1:0]  ring_start,
  output logic           ring_load,
  output logic           irq
);
  logic [2:0]     sts, sts_n, msk, msk_n;
  logic           en_n, stop_n, kick_n, load_n;
  logic [MBW-1:0] mb_n;
  logic [AW-1:0]  ring_n;

  always_comb begin
    en_n   = en;
    stop_n = stop_pend;
    kick_n = kick;
    sts_n  = sts;
    msk_n  = msk;
    mb_n   = max_burst;
    ring_n = ring_start;
    load_n = 1'b0;
    if (kick_ack) kick_n = 1'b0;
    if (stop_pend && eng_idle) begin
      en_n   = 1'b0;
      stop_n = 1'b0;
    end
    if (reg_wr) begin
      case (reg_addr)
        RA_CFG: begin
          if (reg_wdata[0]) begin
            en_n   = 1'b1;
            stop_n = 1'b0;
            kick_n = 1'b1;
          end else if (en) begin
            stop_n = 1'b1;
          end
        end
        RA_STS:  sts_n = sts & ~reg_wdata[2:0];
        RA_MSK:  msk_n = reg_wdata[2:0];
        RA_MBR:  mb_n  = reg_wdata[MBW-1:0];
        RA_RING: begin
          ring_n = reg_wdata[AW-1:0];
          load_n = 1'b1;
        end
        default: ;
      endcase
    end
    sts_n = sts_n | {evt.not_own, evt.pkt_done, evt.buf_done};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= 1'b0;
      stop_pend  <= 1'b0;
      kick       <= 1'b0;
      sts        <= '0;
      msk        <= '0;
      max_burst  <= MBW'(MB_RST);
      ring_start <= '0;
      ring_load  <= 1'b0;
    end else begin
      en         <= en_n;
      stop_pend  <= stop_n;
      kick       <= kick_n;
      sts        <= sts_n;
      msk        <= msk_n;
      max_burst  <= mb_n;
      ring_start <= ring_n;
      ring_load  <= load_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CFG:  reg_rdata = {31'd0, en};
      RA_STS:  reg_rdata = {29'd0, sts};
      RA_MSK:  reg_rdata = {29'd0, msk};
      RA_MBR:  reg_rdata = 32'(max_burst);
      RA_RING: reg_rdata = 32'(ring_start);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(sts & msk);
endmodule

// File: rtl/txr_engine.sv
`timescale 1ns/1ps
module txr_engine
  import txr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int MBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           stop_pend,
  input  logic           kick,
  input  logic [MBW-1:0] max_burst,
  input  logic [AW-1:0]  ring_start,
  input  logic           ring_load,
  output logic           kick_ack,
  output logic           eng_idle,
  output eng_evt_t       evt,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           mem_bstart,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  output logic           buf_rd,
  output logic           st_valid,
  output logic [7:0]     st_data,
  output logic           st_sop,
  output logic           st_eop,
  output logic           st_crc
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);
  localparam logic [AW-1:0] DESC_STEP = AW'(8);
  localparam logic [31:0]   OWN_CLR   = ~(32'h1 << LS_OWN);

  eng_state_e          state, state_n;
  logic [AW-1:0]       cur, cur_n, bptr, bptr_n;
  logic [31:0]         ls, ls_n, wbuf, wbuf_n;
  logic [LS_LEN_W-1:0] rem, rem_n;
  logic [1:0]          bidx, bidx_n;
  logic                first, first_n;
  logic [MBW-1:0]      bcnt, bcnt_n, eff;

  assign eff      = (max_burst == '0) ? MBW'(1) : max_burst;
  assign eng_idle = (state == ST_IDLE);

  always_comb begin
    state_n = state;  cur_n = cur;   ls_n = ls;     bptr_n = bptr;
    rem_n   = rem;    bidx_n = bidx; first_n = first;
    bcnt_n  = bcnt;   wbuf_n = wbuf;
    mem_rd = 1'b0; mem_wr = 1'b0; mem_bstart = 1'b0; buf_rd = 1'b0;
    mem_addr = '0; mem_wdata = '0;
    st_valid = 1'b0; st_data = '0; st_sop = 1'b0; st_eop = 1'b0; st_crc = 1'b0;
    evt = '0; kick_ack = 1'b0;
    case (state)
      ST_IDLE: if (en && kick && !stop_pend) begin
        kick_ack = 1'b1;
        state_n  = ST_RD_LS;
      end
      ST_RD_LS: begin
        mem_rd = 1'b1; mem_bstart = 1'b1; mem_addr = cur;
        state_n = ST_RD_AD;
      end
      ST_RD_AD: begin
        ls_n = mem_rdata;
        if (mem_rdata[LS_OWN]) begin
          mem_rd = 1'b1; mem_addr = cur + WORD_STEP;
          state_n = ST_CAP;
        end else begin
          evt.not_own = 1'b1;
          state_n = ST_IDLE;
        end
      end
      ST_CAP: begin
        bptr_n  = mem_rdata[AW-1:0];
        rem_n   = ls[LS_LEN_LSB +: LS_LEN_W];
        first_n = 1'b1;
        bcnt_n  = '0;
        state_n = ST_BUF_RD;
      end
      ST_BUF_RD: begin
        if (rem == '0) begin
          state_n = ST_WB;
        end else begin
          mem_rd = 1'b1; buf_rd = 1'b1; mem_addr = bptr;
          mem_bstart = (bcnt == '0);
          bptr_n = bptr + WORD_STEP;
          bcnt_n = (({1'b0, bcnt} + 1'b1) >= {1'b0, eff}) ? '0 : bcnt + 1'b1;
          state_n = ST_BUF_OUT;
        end
      end
      ST_BUF_OUT: begin
        wbuf_n  = mem_rdata;
        bidx_n  = '0;
        state_n = ST_EMIT;
      end
      ST_EMIT: begin
        st_valid = 1'b1;
        st_data  = wbuf[{bidx, 3'b000} +: 8];
        st_sop   = first && ls[LS_SOP];
        st_eop   = (rem == LS_LEN_W'(1)) && ls[LS_EOP];
        st_crc   = ls[LS_CRC];
        rem_n    = rem - 1'b1;
        bidx_n   = bidx + 1'b1;
        first_n  = 1'b0;
        if (rem == LS_LEN_W'(1))  state_n = ST_WB;
        else if (bidx == 2'd3)    state_n = ST_BUF_RD;
      end
      ST_WB: begin
        mem_wr = 1'b1; mem_addr = cur; mem_wdata = ls & OWN_CLR;
        evt.buf_done = 1'b1;
        evt.pkt_done = ls[LS_EOP];
        cur_n   = ls[LS_WRAP] ? ring_start : cur + DESC_STEP;
        state_n = (en && !stop_pend) ? ST_RD_LS : ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
    if (ring_load) cur_n = ring_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cur <= '0; ls <= '0; bptr <= '0; rem <= '0;
      bidx <= '0; first <= 1'b0; bcnt <= '0; wbuf <= '0;
    end else begin
      state <= state_n; cur <= cur_n; ls <= ls_n; bptr <= bptr_n; rem <= rem_n;
      bidx <= bidx_n; first <= first_n; bcnt <= bcnt_n; wbuf <= wbuf_n;
    end
  end
endmodule

// File: rtl/txring_dma.sv
`timescale 1ns/1ps
module txring_dma
  import txr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MBW    = 8,
  parameter int MB_RST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_bstart,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          st_valid,
  output logic [7:0]    st_data,
  output logic          st_sop,
  output logic          st_eop,
  output logic          st_crc
);
  logic [1:0]     rst_q;
  logic           rst_i;
  logic           en_w, stop_w, kick_w, kick_ack_w, idle_w, load_w, buf_rd_w;
  logic [MBW-1:0] mb_w;
  logic [AW-1:0]  ring_w;
  eng_evt_t       evt_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  txr_regs #(.AW(AW), .MBW(MBW), .MB_RST(MB_RST)) u_regs (
    .clk(clk), .rst_n(rst_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt_w),
    .eng_idle(idle_w), .kick_ack(kick_ack_w), .en(en_w), .stop_pend(stop_w),
    .kick(kick_w), .max_burst(mb_w), .ring_start(ring_w), .ring_load(load_w),
    .irq(irq)
  );

  txr_engine #(.AW(AW), .MBW(MBW)) u_eng (
    .clk(clk), .rst_n(rst_i), .en(en_w), .stop_pend(stop_w), .kick(kick_w),
    .max_burst(mb_w), .ring_start(ring_w), .ring_load(load_w),
    .kick_ack(kick_ack_w), .eng_idle(idle_w), .evt(evt_w),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_bstart(mem_bstart),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .buf_rd(buf_rd_w), .st_valid(st_valid), .st_data(st_data),
    .st_sop(st_sop), .st_eop(st_eop), .st_crc(st_crc)
  );
endmodule

// File: rtl/txring_dma_chk.sv
`timescale 1ns/1ps
module txring_dma_chk #(
  parameter int AW  = 32,
  parameter int MBW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           mem_bstart,
  input logic [AW-1:0]  mem_addr,
  input logic           wb_own,
  input logic           wb_wrap,
  input logic           st_valid,
  input logic           st_eop,
  input logic           en,
  input logic           eng_idle,
  input logic           buf_rd,
  input logic [AW-1:0]  ring_start,
  input logic [MBW-1:0] max_burst
);
  logic [MBW:0] run;
  logic [MBW:0] eff;
  assign eff = (max_burst == '0) ? (MBW+1)'(1) : {1'b0, max_burst};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run <= '0;
    else if (mem_rd && buf_rd)  run <= mem_bstart ? (MBW+1)'(1) : run + 1'b1;
  end

  assert_one_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !mem_wr);
  assert_wb_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !wb_own);
  assert_wrap_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && wb_wrap) |=> (!mem_rd || mem_addr == ring_start));
  assert_en_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> en);
  assert_en_drop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> eng_idle);
  assert_burst_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && buf_rd && !mem_bstart) |-> (run < eff));
  assert_eop_then_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_eop) |=> mem_wr);
endmodule

bind txring_dma txring_dma_chk #(.AW(AW), .MBW(MBW)) u_chk (
  .clk(clk), .rst_n(rst_i), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_bstart(mem_bstart), .mem_addr(mem_addr), .wb_own(mem_wdata[15]),
  .wb_wrap(mem_wdata[12]), .st_valid(st_valid), .st_eop(st_eop),
  .en(en_w), .eng_idle(idle_w), .buf_rd(buf_rd_w), .ring_start(ring_w),
  .max_burst(mb_w)
);

// File: tb/test_txring_dma.sv
`timescale 1ns/1ps
module test_txring_dma;
  localparam int AW = 32;
  localparam logic [4:0] A_CFG = 5'h00, A_STS = 5'h04, A_MSK = 5'h08,
                         A_MBR = 5'h0C, A_RING = 5'h10;

  typedef struct packed {
    logic [11:0] len;
    logic        sop;
    logic        eop;
    logic        crc;
    logic [7:0]  mb;
    logic [7:0]  nburst;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{12'd64,  1'b1, 1'b1, 1'b1, 8'd8,  8'd2},
    '{12'd13,  1'b1, 1'b1, 1'b0, 8'd8,  8'd1},
    '{12'd1,   1'b1, 1'b0, 1'b1, 8'd2,  8'd1},
    '{12'd40,  1'b0, 1'b1, 1'b0, 8'd3,  8'd4},
    '{12'd9,   1'b1, 1'b1, 1'b1, 8'd0,  8'd3},
    '{12'd100, 1'b1, 1'b1, 1'b0, 8'd32, 8'd1},
    '{12'd0,   1'b1, 1'b1, 1'b0, 8'd8,  8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          reg_wr = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq, mem_rd, mem_wr, mem_bstart;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          st_valid, st_sop, st_eop, st_crc;
  logic [7:0]    st_data;

  txring_dma #(.AW(AW)) i_txring_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_bstart(mem_bstart),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .st_valid(st_valid), .st_data(st_data), .st_sop(st_sop),
    .st_eop(st_eop), .st_crc(st_crc)
  );

  // memory model, one cycle read latency
  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
  end

  function automatic logic [7:0] pb(input int b);
    return 8'(b) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] mk_ls(input logic [11:0] len, input logic own,
      input logic eop, input logic sop, input logic wrap, input logic crc,
      input logic [7:0] low);
    return {4'h0, len, own, eop, sop, wrap, 3'b000, crc, low};
  endfunction

  // monitor, sampled on the falling edge
  int nbytes, sop_cnt, eop_cnt, sop_pos, eop_pos, crc_hi;
  int bursts, run, maxrun, nfetch, nwb;
  logic [7:0]  cap [0:255];
  logic [31:0] fetch_a [0:7];
  logic [31:0] wb_addr, wb_data;

  always @(negedge clk) if (rst_n) begin
    if (st_valid) begin
      if (nbytes < 256) cap[nbytes] = st_data;
      if (st_sop) begin sop_cnt++; sop_pos = nbytes; end
      if (st_eop) begin eop_cnt++; eop_pos = nbytes; end
      if (st_crc) crc_hi++;
      nbytes++;
    end
    if (mem_rd && mem_addr >= 32'h200) begin
      if (mem_bstart) begin bursts++; run = 1; end
      else run++;
      if (run > maxrun) maxrun = run;
    end
    if (mem_rd && mem_bstart && mem_addr < 32'h200) begin
      if (nfetch < 8) fetch_a[nfetch] = mem_addr;
      nfetch++;
    end
    if (mem_wr) begin nwb++; wb_addr = mem_addr; wb_data = mem_wdata; end
  end

  task automatic clr_mon();
    nbytes = 0; sop_cnt = 0; eop_cnt = 0; sop_pos = -1; eop_pos = -1; crc_hi = 0;
    bursts = 0; run = 0; maxrun = 0; nfetch = 0; nwb = 0;
  endtask

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rwr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rrd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_wb(input int n);
    for (int t = 0; t < 5000 && nwb < n; t++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    for (int w = 0; w < 256; w++)
      mem[w] = (w >= 128) ? {pb(4*w+3), pb(4*w+2), pb(4*w+1), pb(4*w)} : 32'h0;
    clr_mon();
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    rrd(A_CFG, rd);  chk("R1 cfg", rd, 32'h0);
    rrd(A_STS, rd);  chk("R1 sts", rd, 32'h0);
    rrd(A_MSK, rd);  chk("R1 msk", rd, 32'h0);
    rrd(A_MBR, rd);  chk("R1 maxburst", rd, 32'd8);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 no stream", 32'(nbytes), 32'h0);

    // vector table walk: R2 R3 R6 R8 R9 R10 R11 R12
    for (int i = 0; i < 7; i++) begin
      vec_t v;
      logic [31:0] ls;
      int words, eff, expmax, mism;
      v = VECS[i];
      ls = mk_ls(v.len, 1'b1, v.eop, v.sop, 1'b0, v.crc, 8'hA0 | 8'(i));
      rwr(A_RING, 32'h40);
      rwr(A_STS, 32'h7);
      rwr(A_MBR, 32'(v.mb));
      mem[16] = ls; mem[17] = 32'h200; mem[18] = 32'h0; mem[19] = 32'h0;
      clr_mon();
      rwr(A_CFG, 32'h1);
      wait_wb(1);
      idle(6);
      words  = (int'(v.len) + 3) / 4;
      eff    = (v.mb == 0) ? 1 : int'(v.mb);
      expmax = (words < eff) ? words : eff;
      mism = 0;
      for (int k = 0; k < int'(v.len); k++) if (cap[k] !== pb(32'h200 + k)) mism++;
      chk("R12 first fetch at new ring start", fetch_a[0], 32'h40);
      chk("R3 byte count", 32'(nbytes), 32'(v.len));
      chk("R3 byte order", 32'(mism), 32'h0);
      chk("R3 writeback addr", wb_addr, 32'h40);
      chk("R2 R3 writeback word", wb_data, ls & ~32'h8000);
      chk("R10 sop count", 32'(sop_cnt), 32'((v.len != 0 && v.sop) ? 1 : 0));
      if (v.len != 0 && v.sop) chk("R10 sop position", 32'(sop_pos), 32'h0);
      chk("R10 eop count", 32'(eop_cnt), 32'((v.len != 0 && v.eop) ? 1 : 0));
      if (v.len != 0 && v.eop) chk("R10 eop position", 32'(eop_pos), 32'(v.len) - 1);
      chk("R10 crc flag bytes", 32'(crc_hi), v.crc ? 32'(v.len) : 32'h0);
      chk("R9 R11 bursts", 32'(bursts), 32'(v.nburst));
      chk("R9 longest burst", 32'(maxrun), 32'(expmax));
      chk("R4 sequential fetch", fetch_a[1], 32'h48);
      chk("R8 fetch count", 32'(nfetch), 32'd2);
      rrd(A_STS, rd);
      chk("R6 R8 status", rd, {29'd0, 1'b1, v.eop, 1'b1});
      rwr(A_CFG, 32'h0);
      idle(2);
      rrd(A_CFG, rd);  chk("R5 stop while idle", rd, 32'h0);
    end

    // R4 and R8: wrap back to ring start, then re-check on enable
    rwr(A_RING, 32'h80);
    rwr(A_STS, 32'h7);
    rwr(A_MBR, 32'd8);
    mem[32] = mk_ls(12'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00); mem[33] = 32'h200;
    mem[34] = mk_ls(12'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00); mem[35] = 32'h204;
    clr_mon();
    rwr(A_CFG, 32'h1);
    wait_wb(2);
    idle(8);
    chk("R4 fetch count", 32'(nfetch), 32'd3);
    chk("R4 fetch 0", fetch_a[0], 32'h80);
    chk("R4 fetch 1", fetch_a[1], 32'h88);
    chk("R4 wrap fetch", fetch_a[2], 32'h80);
    chk("R3 second buffer byte", 32'(cap[4]), 32'(pb(32'h204)));
    rrd(A_STS, rd);  chk("R8 not-owner set", 32'(rd[2]), 32'h1);
    rwr(A_STS, 32'h7);
    mem[32] = mem[32] | 32'h8000;
    clr_mon();
    idle(20);
    chk("R8 no fetch without enable write", 32'(nfetch), 32'h0);
    rwr(A_CFG, 32'h1);
    wait_wb(1);
    idle(8);
    chk("R8 refetch same descriptor", fetch_a[0], 32'h80);
    chk("R8 refetch streams", 32'(nbytes), 32'd4);
    chk("R8 refetch writeback", 32'(nwb), 32'd1);
    rwr(A_CFG, 32'h0);
    idle(2);

    // R5: stop while a descriptor is in flight
    rwr(A_RING, 32'h40);
    rwr(A_STS, 32'h7);
    mem[16] = mk_ls(12'd100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00); mem[17] = 32'h200;
    mem[18] = mk_ls(12'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);   mem[19] = 32'h200;
    clr_mon();
    rwr(A_CFG, 32'h1);
    for (int t = 0; t < 200 && nbytes == 0; t++) begin @(posedge clk); #1; end
    rwr(A_CFG, 32'h0);
    rrd(A_CFG, rd);  chk("R5 enable held in flight", rd, 32'h1);
    wait_wb(1);
    idle(6);
    rrd(A_CFG, rd);  chk("R5 enable low after writeback", rd, 32'h0);
    chk("R5 in-flight frame complete", 32'(nbytes), 32'd100);
    chk("R5 no further fetch", 32'(nfetch), 32'd1);
    chk("R5 next descriptor untouched", 32'(mem[18][15]), 32'h1);

    // R6 R7: status clear and interrupt mask
    rrd(A_STS, rd);  chk("R6 done bits", rd, 32'h3);
    chk("R7 irq masked off", 32'(irq), 32'h0);
    rwr(A_MSK, 32'h2);
    chk("R7 irq on packet done", 32'(irq), 32'h1);
    rwr(A_STS, 32'h2);
    rrd(A_STS, rd);  chk("R6 write-one clears bit 1 only", rd, 32'h1);
    chk("R7 irq drops", 32'(irq), 32'h0);
    rwr(A_STS, 32'h0);
    rrd(A_STS, rd);  chk("R6 write zero no effect", rd, 32'h1);
    rwr(A_MSK, 32'h1);
    chk("R7 irq on buffer done", 32'(irq), 32'h1);
    rwr(A_STS, 32'h1);
    rrd(A_STS, rd);  chk("R6 all clear", rd, 32'h0);
    chk("R7 irq low", 32'(irq), 32'h0);

    finish_run();
  end
endmodule